// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes and completes one instruction per rising clock edge. It has a program counter, a 32-entry register file, a sign extender, target logic for branches and jumps, an ALU, and the multiplexers that connect them. Two word-addressed arrays inside the block serve as instruction memory and data memory. Decoding happens in two levels. A main decoder turns the opcode into seven datapath controls, a jump select and a 2-bit ALU operation class. A second decoder combines that class with the function field to pick the ALU function.

The supported instructions are word load, word store, register add, subtract, and, or and signed set-less-than, plus branch-if-equal and unconditional jump. While reset is held, the surrounding logic fills either memory through a load port. Any register can be read at any time through a combinational debug read port. The current program counter is also a block output.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0. The first instruction after reset is fetched from address 0.
- R2: Any instruction that is neither a taken beq nor a jump advances the PC by exactly 4.
- R3: Register-type instructions (opcode 0, fields op[31:26] rs[25:21] rt[20:16] rd[15:11] funct[5:0]) write rd with rs+rt (funct 0x20), rs-rt (0x22), rs AND rt (0x24) or rs OR rt (0x25).
- R4: Funct 0x2A writes 1 to rd when rs is less than rt as signed values, and 0 otherwise.
- R5: A load (opcode 35) writes rt with the data word at byte address rs + sign-extended imm[15:0]. Negative offsets work.
- R6: A store (opcode 43) writes rt to the data word at rs + sign-extended imm and writes no register. A later load of that address returns the stored value.
- R7: beq (opcode 4) compares rs and rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2 (backward offsets included). Otherwise the PC advances by 4.
- R8: A jump (opcode 2) sets the PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R9: Register 0 always reads 0, and a write to it has no effect.
- R10: An opcode outside {0, 2, 4, 35, 43} writes no register and no memory, and only advances the PC.
- R11: An instruction that reads and writes the same register in one cycle uses the old value as its operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel_dmem | input | 1 | Load-port target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Load-port word index |
| ld_data | input | 32 | Load-port write word |
| dbg_raddr | input | 5 | Debug register index |
| dbg_rdata | output | 32 | Debug register value (combinational) |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume that every fetched instruction is fully defined and that the load port is used only while reset is held. They also assume that load and store addresses are word aligned. The stimulus keeps to these limits. It loads both memories before releasing reset. It computes every memory address from a base that was loaded earlier, and that base is a multiple of 4. It reads no register until the program has written it. It ends in a self-branch, so the core never fetches from an unfilled location.

// File: rtl/core_pkg.sv
// Shared types and encodings for the single-cycle core.
// Assumes a fixed 32-bit word and the field layout given in the brief.
package core_pkg;
    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_JUMP  = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_LOAD  = 6'd35;
    localparam logic [5:0] OP_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_ctrl_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } aluop_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        aluop_e aluop;
    } ctrl_t;
endpackage

// File: rtl/sc_wordmem.sv
// Word-wide storage array with one synchronous write port and one
// combinational read port. Assumes indices are already word indices.
module sc_wordmem #(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store one word on the rising edge when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sc_regfile.sv
// Register file with NRD combinational read ports and one write port.
// Index 0 reads zero and ignores writes. A read in the cycle of a write
// to the same index returns the old value.
module sc_regfile #(
    parameter int AW  = 5,
    parameter int W   = 32,
    parameter int NRD = 3
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    // Write one register per edge; index 0 is never stored.
    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Combinational read with the zero register forced.
        always_comb begin
            if (raddr[p] == '0) begin
                rdata[p] = '0;
            end else begin
                rdata[p] = regs[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/sc_main_dec.sv
// First decode level: opcode to datapath controls and ALU operation class.
// Assumes undefined opcodes must become a no-op (all enables low).
module sc_main_dec
    import core_pkg::*;
(
    input  logic [5:0] op,
    output ctrl_t      ctl
);
    // Per-opcode control word; don't-care outputs are driven low.
    always_comb begin
        ctl = '{reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0,
                reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0,
                branch: 1'b0, jump: 1'b0, aluop: AOP_ADD};
        case (op)
            OP_RTYPE: begin
                ctl.reg_dst   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.aluop     = AOP_FUNCT;
            end
            OP_LOAD: begin
                ctl.alu_src    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_write  = 1'b1;
                ctl.mem_read   = 1'b1;
            end
            OP_STORE: begin
                ctl.alu_src   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.aluop  = AOP_SUB;
            end
            OP_JUMP: begin
                ctl.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
// Second decode level: ALU operation class plus funct to ALU function.
// Assumes unknown funct codes under the funct class fall back to add.
module sc_alu_dec
    import core_pkg::*;
(
    input  aluop_e     aluop,
    input  logic [5:0] funct,
    output alu_ctrl_e  alu_ctrl
);
    // Select the ALU function from the class and, if deferred, funct.
    always_comb begin
        alu_ctrl = ALU_ADD;
        case (aluop)
            AOP_ADD: alu_ctrl = ALU_ADD;
            AOP_SUB: alu_ctrl = ALU_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FN_ADD:  alu_ctrl = ALU_ADD;
                    FN_SUB:  alu_ctrl = ALU_SUB;
                    FN_AND:  alu_ctrl = ALU_AND;
                    FN_OR:   alu_ctrl = ALU_OR;
                    FN_SLT:  alu_ctrl = ALU_SLT;
                    default: alu_ctrl = ALU_ADD;
                endcase
            end
            default: alu_ctrl = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
// Combinational ALU: and, or, add, subtract, signed set-less-than.
// The zero flag reports an all-zero result.
module sc_alu
    import core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctrl_e    ctrl,
    output logic [W-1:0] y,
    output logic         zero
);
    logic lt;

    assign lt = $signed(a) < $signed(b);

    // Compute the result for the selected function.
    always_comb begin
        case (ctrl)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, memories, register file, decoders, ALU and
// datapath muxes. Assumes the load port is used only while rst_n is low;
// register and store writes are gated off during reset.
module sc_core
    import core_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic             ld_sel_dmem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [RAW-1:0]   dbg_raddr,
    output logic [XLEN-1:0]  dbg_rdata,
    output logic [XLEN-1:0]  pc_o
);
    localparam int W = XLEN;

    logic [W-1:0]   pc_q, pc_plus4, pc_next, instr;
    logic [W-1:0]   sext, br_target, j_target;
    logic [W-1:0]   rs_val, rt_val, alu_b, alu_y, wr_data;
    logic [W-1:0]   dm_raw, dm_rdata;
    logic [5:0]     op, funct;
    logic [RAW-1:0] rs, rt, rd, wr_reg;
    ctrl_t          ctl;
    alu_ctrl_e      alu_ctrl;
    logic           alu_zero, branch_taken, reg_we, dm_we;
    logic           im_we, dm_wen;
    logic [DMEM_AW-1:0] dm_waddr;
    logic [W-1:0]   dm_wdata;
    logic [2:0][RAW-1:0] rf_raddr;
    logic [2:0][W-1:0]   rf_rdata;

    // Program counter register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign im_we = ld_we & ~ld_sel_dmem;

    sc_wordmem #(.AW(IMEM_AW), .W(W)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr[IMEM_AW-1:0]),
        .wdata (ld_data),
        .raddr (pc_q[IMEM_AW+1:2]),
        .rdata (instr)
    );

    assign op    = instr[31:26];
    assign rs    = instr[25:21];
    assign rt    = instr[20:16];
    assign rd    = instr[15:11];
    assign funct = instr[5:0];
    assign sext  = {{(W-16){instr[15]}}, instr[15:0]};

    sc_main_dec u_main_dec (
        .op  (op),
        .ctl (ctl)
    );

    sc_alu_dec u_alu_dec (
        .aluop    (ctl.aluop),
        .funct    (funct),
        .alu_ctrl (alu_ctrl)
    );

    assign rf_raddr = {dbg_raddr, rt, rs};
    assign rs_val    = rf_rdata[0];
    assign rt_val    = rf_rdata[1];
    assign dbg_rdata = rf_rdata[2];

    assign wr_reg = ctl.reg_dst ? rd : rt;
    assign reg_we = ctl.reg_write & rst_n;

    sc_regfile #(.AW(RAW), .W(W), .NRD(3)) u_rf (
        .clk   (clk),
        .we    (reg_we),
        .waddr (wr_reg),
        .wdata (wr_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    assign alu_b = ctl.alu_src ? sext : rt_val;

    sc_alu #(.W(W)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .ctrl (alu_ctrl),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_we    = ctl.mem_write & rst_n;
    assign dm_wen   = (ld_we & ld_sel_dmem) | dm_we;
    assign dm_waddr = ld_we ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
    assign dm_wdata = ld_we ? ld_data : rt_val;

    sc_wordmem #(.AW(DMEM_AW), .W(W)) u_dmem (
        .clk   (clk),
        .we    (dm_wen),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[DMEM_AW+1:2]),
        .rdata (dm_raw)
    );

    assign dm_rdata = ctl.mem_read ? dm_raw : '0;
    assign wr_data  = ctl.mem_to_reg ? dm_rdata : alu_y;

    assign pc_plus4     = pc_q + W'(4);
    assign br_target    = pc_plus4 + {sext[W-3:0], 2'b00};
    assign j_target     = {pc_plus4[W-1:W-4], instr[25:0], 2'b00};
    assign branch_taken = ctl.branch & alu_zero;

    // Next-PC select: jump, taken branch, or sequential.
    always_comb begin
        if (ctl.jump) begin
            pc_next = j_target;
        end else if (branch_taken) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/sc_core_chk.sv
// Checker for sc_core, attached by bind. Observes PC sequencing, write
// enables and the debug port.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_q,
    input logic [31:0] br_target,
    input logic [31:0] j_target,
    input logic        branch_taken,
    input logic        jump,
    input logic        reg_we,
    input logic        dm_we,
    input logic [5:0]  op,
    input logic [4:0]  dbg_raddr,
    input logic [31:0] dbg_rdata
);
    // R1
    pc_reset_chk: assert property (@(posedge clk) !rst_n |=> (pc_q == 32'd0));

    // R2
    pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!branch_taken && !jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // R7
    pc_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_taken && !jump) |=> (pc_q == $past(br_target)));

    // R8
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> (pc_q == $past(j_target)));

    // R6
    store_noreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !reg_we);

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_raddr == 5'd0) |-> (dbg_rdata == 32'd0));

    // R10
    undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op inside {6'd0, 6'd2, 6'd4, 6'd35, 6'd43}) |-> (!reg_we && !dm_we && !jump && !branch_taken));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_q         (pc_q),
    .br_target    (br_target),
    .j_target     (j_target),
    .branch_taken (branch_taken),
    .jump         (ctl.jump),
    .reg_we       (reg_we),
    .dm_we        (dm_we),
    .op           (op),
    .dbg_raddr    (dbg_raddr),
    .dbg_rdata    (dbg_rdata)
);

// File: tb/tb_sc_core.sv
// Scoreboard bench: driver tasks queue expected PCs and register values;
// monitors pop and compare them against the ports.
module tb_sc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_sel_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] pc_o;

    int total = 0;
    int bad = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;

    typedef struct { logic [31:0] val; string tag; } pc_item_t;
    typedef struct { logic [4:0] idx; logic [31:0] val; string tag; } reg_item_t;
    pc_item_t  pc_exp[$];
    reg_item_t reg_exp[$];

    sc_core dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel_dmem(ld_sel_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_raddr(dbg_raddr),
        .dbg_rdata(dbg_rdata), .pc_o(pc_o)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic load_word(logic sel, int addr, logic [31:0] data);
        @(negedge clk);
        ld_we = 1'b1; ld_sel_dmem = sel; ld_addr = 6'(addr); ld_data = data;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic push_pc(logic [31:0] val, string tag);
        pc_item_t it;
        it.val = val; it.tag = tag;
        pc_exp.push_back(it);
    endtask

    task automatic push_reg(int idx, logic [31:0] val, string tag);
        reg_item_t it;
        it.idx = 5'(idx); it.val = val; it.tag = tag;
        reg_exp.push_back(it);
    endtask

    // PC monitor: compare one queued PC per cycle, away from the edge.
    always @(negedge clk) begin
        if (mon_en && pc_exp.size() > 0) begin
            pc_item_t it;
            it = pc_exp.pop_front();
            check(it.tag, pc_o, it.val);
        end
    end

    // Register monitor: drain queued register values via the debug port.
    task automatic drain_regs();
        while (reg_exp.size() > 0) begin
            reg_item_t it;
            it = reg_exp.pop_front();
            dbg_raddr = it.idx;
            #1;
            check(it.tag, dbg_rdata, it.val);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] prog [25];
        // Data preload.
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'hFFFF_FFFD);
        load_word(1'b1, 2, 32'h0F0F_00FF);
        load_word(1'b1, 3, 32'h1234_5678);
        load_word(1'b1, 4, 32'd16);
        // Program.
        prog[0]  = itype(6'd35, 0, 1, 16'd0);
        prog[1]  = itype(6'd35, 0, 2, 16'd4);
        prog[2]  = itype(6'd35, 0, 3, 16'd8);
        prog[3]  = itype(6'd35, 0, 4, 16'd12);
        prog[4]  = rtype(1, 2, 5, 6'h20);
        prog[5]  = rtype(1, 2, 6, 6'h22);
        prog[6]  = rtype(3, 4, 7, 6'h24);
        prog[7]  = rtype(3, 4, 8, 6'h25);
        prog[8]  = rtype(2, 1, 9, 6'h2A);
        prog[9]  = rtype(1, 2, 10, 6'h2A);
        prog[10] = rtype(1, 1, 0, 6'h20);
        prog[11] = rtype(1, 1, 1, 6'h20);
        prog[12] = itype(6'd35, 0, 11, 16'd16);
        prog[13] = itype(6'd43, 11, 4, 16'd4);
        prog[14] = itype(6'd35, 11, 12, 16'hFFF4);
        prog[15] = itype(6'd35, 0, 13, 16'd20);
        prog[16] = itype(6'd4, 1, 2, 16'd5);
        prog[17] = itype(6'd4, 12, 2, 16'd2);
        prog[18] = rtype(0, 0, 1, 6'h20);
        prog[19] = rtype(0, 0, 1, 6'h20);
        prog[20] = itype(6'h3F, 1, 1, 16'h0800);
        prog[21] = {6'd2, 26'd24};
        prog[22] = rtype(0, 0, 1, 6'h20);
        prog[23] = rtype(0, 0, 1, 6'h20);
        prog[24] = itype(6'd4, 0, 0, 16'hFFFF);
        for (int i = 0; i < 25; i++) load_word(1'b0, i, prog[i]);

        @(negedge clk);
        check("R1 pc in reset", pc_o, 32'd0);

        for (int i = 1; i <= 17; i++) push_pc(32'(i * 4), "R2 sequential pc");
        push_pc(32'd80, "R7 beq taken forward");
        push_pc(32'd84, "R10 undefined op advances pc");
        push_pc(32'd96, "R8 jump target");
        push_pc(32'd96, "R7 beq backward self loop");
        push_pc(32'd96, "R7 beq backward self loop");

        rst_n = 1'b1;
        @(posedge clk);
        mon_en = 1'b1;
        while (pc_exp.size() != 0) @(posedge clk);
        @(negedge clk);
        mon_en = 1'b0;

        push_reg(0, 32'd0, "R9 r0 ignores write");
        push_reg(1, 32'd10, "R11 old operand; R10 R7 skipped writes");
        push_reg(2, 32'hFFFF_FFFD, "R5 load");
        push_reg(3, 32'h0F0F_00FF, "R5 load");
        push_reg(5, 32'd2, "R3 add");
        push_reg(6, 32'd8, "R3 sub");
        push_reg(7, 32'h0204_0078, "R3 and");
        push_reg(8, 32'h1F3F_56FF, "R3 or");
        push_reg(9, 32'd1, "R4 slt true signed");
        push_reg(10, 32'd0, "R4 slt false");
        push_reg(11, 32'd16, "R5 load base");
        push_reg(12, 32'hFFFF_FFFD, "R5 negative offset");
        push_reg(13, 32'h1234_5678, "R6 store then load");
        push_reg(4, 32'h1234_5678, "R6 store source kept");
        drain_regs();

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pc after mid-run reset", pc_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first fetch from 0 then R2", pc_o, 32'd4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule